// File: doc/BRIEF.md
# Automatic Line Feed Activation Controller

This block sits between the latched three-bit mode word written by a line-card controller and the analog feed stage of a subscriber line interface. When the controller asks for the active group of modes, the block chooses the internal feeding state on its own. On-hook, the line rests in a low-power high-impedance feeding state. A suspected off-hook is validated in stand-by. A confirmed off-hook moves the line to full active feeding. A hang-up is only accepted after a long timeout, so pulse dialling does not tear down the call.

The block also handles the two automatic exits to active feeding. A ring-trip ends ringing, and an off-hook ends on-hook transmission. It outputs the feeding state, the line polarity and the active-low off-hook indication. All timeouts count rising edges of an external slow clock at the ringing frequency, which is first brought into the block clock domain. The analog detectors are outside the block and provide already-qualified off-hook and ring-trip flags, synchronous to the block clock.

Mode word encoding (`mode_word[2:0]`): `000` power-down, `001` ringing, `010` on-hook transmission reverse polarity, `011` on-hook transmission direct polarity, `110` active reverse polarity, `100`/`101`/`111` active direct polarity (the default words). State code on `feed_state`: 0 power-down, 1 high-impedance feeding, 2 stand-by, 3 active, 4 ringing, 5 on-hook transmission.

Top module: `auto_line_act`

## Requirements
- R1: While `rst_n` is low, `feed_state` is 0 (power-down), `det_n` is 1 and `rev_pol` is 0, and `feed_state` only ever takes codes 0 to 5.
- R2: A mode word with bit 2 set, appearing after reset or after a word outside the active group, enters high-impedance feeding (code 1) with `rev_pol` 0, even for word `110`.
- R3: In high-impedance feeding, `ohf_hi` high moves the block to stand-by (code 2) on the next clock edge.
- R4: In stand-by, `ohf_act` high moves the block to active (code 3) on the next clock edge, and `det_n` is driven low.
- R5: In stand-by without `ohf_act`, the block stays in stand-by through 127 rising edges of `ring_clk` and returns to high-impedance feeding after the 128th (`HOLD_EDGES`).
- R6: In active with an active-group word, `det_n` equals the inverse of `ohf_act` without waiting for any timeout, and the state stays active through 127 ring-clock edges of on-hook.
- R7: If `ohf_act` returns during the on-hook hold, the block stays active with `det_n` low, and the next on-hook starts a fresh count from zero.
- R8: When the hold expires with a default word (`100`, `101`, `111`), the block falls back to high-impedance feeding. With word `110`, it stays active with `rev_pol` 1.
- R9: In ringing (word `001`, code 4), `ring_trip` moves the block to active and latches `det_n` low regardless of `ohf_act`, until the mode word changes.
- R10: In on-hook transmission (word `01x`, code 5), `ohf_act` moves the block to active. In these states and in active, `rev_pol` is 1 exactly for words `010` and `110`.
- R11: Word `000` forces power-down with `det_n` 1 and `rev_pol` 0. A word change that leaves the active group cancels any pending timeout, so no later fallback occurs.
- R12: A word change inside the active group (bit 2 stays set) keeps the current feeding state and only updates polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (free-running) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 3 | Latched operating mode word from the controller |
| ohf_hi | input | 1 | Off-hook flag valid in high-impedance feeding |
| ohf_act | input | 1 | Off-hook flag valid in stand-by, active and on-hook transmission |
| ring_trip | input | 1 | Ring-trip detected flag |
| ring_clk | input | 1 | External clock at ringing frequency, asynchronous |
| feed_state | output | 3 | Internal feeding state code |
| rev_pol | output | 1 | 1 selects reversed line polarity |
| det_n | output | 1 | Active-low off-hook / ring-trip indication |

## Verification
The bench targets the edge of the 128-edge window. It checks 127 edges against 128 edges, both in stand-by and in the active hold. A counter off by one would fall back one edge early or late. A counter that does not restart would drop a call after a second short break. Random break lengths around the window mimic pulse dialling, and a controller that ignored the default-word rule would drop reverse-polarity calls. Directed cases show that a lost ring-trip latch would release `det_n` on an on-hook line. They also show that a leaked pending timeout would pull on-hook transmission back to low-power feeding.

// File: rtl/line_act_pkg.sv
package line_act_pkg;

   typedef enum logic [2:0] {
      ST_PWRDN  = 3'd0,
      ST_HIZ    = 3'd1,
      ST_STBY   = 3'd2,
      ST_ACTIVE = 3'd3,
      ST_RING   = 3'd4,
      ST_OHT    = 3'd5
   } feed_state_e;

   localparam int unsigned WORD_W = 3;

   // bit 2 set: active group, state chosen automatically
   function automatic logic in_active_group(input logic [WORD_W-1:0] w);
      return w[2];
   endfunction

   // active words that allow fallback to low-power feeding
   function automatic logic is_default_active(input logic [WORD_W-1:0] w);
      return w[2] && (w[1:0] != 2'b10);
   endfunction

   function automatic logic wants_reverse(input logic [WORD_W-1:0] w);
      return (w == 3'b110) || (w == 3'b010);
   endfunction

   // state entered when a word arrives from outside its own group
   function automatic feed_state_e entry_state(input logic [WORD_W-1:0] w);
      feed_state_e s;
      if (w[2])
         s = ST_HIZ;
      else if (w[1])
         s = ST_OHT;
      else if (w[0])
         s = ST_RING;
      else
         s = ST_PWRDN;
      return s;
   endfunction

endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   logic [STAGES-1:0] sr;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[i] <= 1'b0;
            else        sr[i] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[i] <= 1'b0;
            else        sr[i] <= sr[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sr[STAGES-1];
   end

   assign rise = sr[STAGES-1] & ~last_q;

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
   parameter int unsigned LIMIT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   input  logic tick,
   output logic busy,
   output logic expired
);

   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   assign busy    = busy_q;
   assign expired = busy_q && tick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (stop) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (busy_q && tick) begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/feed_fsm.sv
module feed_fsm
   import line_act_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] mode_word,
   input  logic              ohf_hi,
   input  logic              ohf_act,
   input  logic              ring_trip,
   input  logic              t_busy,
   input  logic              t_expired,
   output feed_state_e       state,
   output logic              trip_latched,
   output logic              t_start,
   output logic              t_stop
);

   feed_state_e       state_q, state_d;
   logic [WORD_W-1:0] prev_word_q;
   logic              prev_valid_q;
   logic              latch_q, latch_d;
   logic              new_word, intra_group;

   assign new_word    = !prev_valid_q || (mode_word != prev_word_q);
   assign intra_group = prev_valid_q && in_active_group(prev_word_q)
                        && in_active_group(mode_word);

   always_comb begin
      state_d = state_q;
      latch_d = latch_q;
      t_start = 1'b0;
      t_stop  = 1'b0;
      if (new_word && !intra_group) begin
         t_stop  = 1'b1;
         latch_d = 1'b0;
         state_d = entry_state(mode_word);
      end else begin
         if (new_word) latch_d = 1'b0;
         unique case (state_q)
            ST_HIZ: begin
               if (ohf_hi) begin
                  state_d = ST_STBY;
                  t_start = 1'b1;
               end
            end
            ST_STBY: begin
               if (ohf_act) begin
                  state_d = ST_ACTIVE;
                  t_stop  = 1'b1;
               end else if (t_expired) begin
                  state_d = ST_HIZ;
               end
            end
            ST_ACTIVE: begin
               if (ohf_act) begin
                  if (t_busy) t_stop = 1'b1;
               end else if (t_expired) begin
                  if (is_default_active(mode_word)) state_d = ST_HIZ;
               end else if (!t_busy) begin
                  t_start = 1'b1;
               end
            end
            ST_RING: begin
               if (ring_trip) begin
                  state_d = ST_ACTIVE;
                  latch_d = 1'b1;
               end
            end
            ST_OHT: begin
               if (ohf_act) state_d = ST_ACTIVE;
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_PWRDN;
         latch_q      <= 1'b0;
         prev_word_q  <= '0;
         prev_valid_q <= 1'b0;
      end else begin
         state_q      <= state_d;
         latch_q      <= latch_d;
         prev_word_q  <= mode_word;
         prev_valid_q <= 1'b1;
      end
   end

   assign state        = state_q;
   assign trip_latched = latch_q;

endmodule

// File: rtl/auto_line_act.sv
module auto_line_act
   import line_act_pkg::*;
#(
   parameter int unsigned HOLD_EDGES  = 128,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_word,
   input  logic       ohf_hi,
   input  logic       ohf_act,
   input  logic       ring_trip,
   input  logic       ring_clk,
   output logic [2:0] feed_state,
   output logic       rev_pol,
   output logic       det_n
);

   if (HOLD_EDGES < 2) begin : g_bad_hold
      $error("HOLD_EDGES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic        ring_rise;
   logic        t_start, t_stop, t_busy, t_expired;
   logic        trip_latched;
   feed_state_e state;
   logic        uses_act_flag;

   ring_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ring_clk),
      .rise     (ring_rise)
   );

   hold_timer #(.LIMIT(HOLD_EDGES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (t_start),
      .stop    (t_stop),
      .tick    (ring_rise),
      .busy    (t_busy),
      .expired (t_expired)
   );

   feed_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_word    (mode_word),
      .ohf_hi       (ohf_hi),
      .ohf_act      (ohf_act),
      .ring_trip    (ring_trip),
      .t_busy       (t_busy),
      .t_expired    (t_expired),
      .state        (state),
      .trip_latched (trip_latched),
      .t_start      (t_start),
      .t_stop       (t_stop)
   );

   assign uses_act_flag = (state == ST_ACTIVE) || (state == ST_STBY) || (state == ST_OHT);

   assign feed_state = state;
   assign det_n   = !(trip_latched || (uses_act_flag && ohf_act)
                      || ((state == ST_HIZ) && ohf_hi));
   assign rev_pol = ((state == ST_ACTIVE) || (state == ST_OHT)) && wants_reverse(mode_word);

endmodule

// File: rtl/auto_line_act_chk.sv
module auto_line_act_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_word,
   input logic       ohf_hi,
   input logic       ohf_act,
   input logic [2:0] feed_state,
   input logic       rev_pol,
   input logic       det_n
);

   a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      feed_state <= 3'd5);

   a_r2_hiz_direct: assert property (@(posedge clk) disable iff (!rst_n)
      feed_state == 3'd1 |-> !rev_pol);

   a_r3_hiz_to_stby: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_state == 3'd1 && ohf_hi && $stable(mode_word)) |=> feed_state == 3'd2);

   a_r4_stby_to_act: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_state == 3'd2 && ohf_act && $stable(mode_word)) |=> feed_state == 3'd3);

   a_r6_det_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_state == 3'd3 && mode_word[2] && $stable(mode_word)) |-> det_n == !ohf_act);

   a_r9_trip_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_state == 3'd3 && mode_word == 3'b001 && $stable(mode_word)) |-> !det_n);

   a_r10_rev_states: assert property (@(posedge clk) disable iff (!rst_n)
      rev_pol |-> (feed_state == 3'd3 || feed_state == 3'd5));

   a_r11_pwrdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      feed_state == 3'd0 |-> (det_n && !rev_pol));

endmodule

bind auto_line_act auto_line_act_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_word  (mode_word),
   .ohf_hi     (ohf_hi),
   .ohf_act    (ohf_act),
   .feed_state (feed_state),
   .rev_pol    (rev_pol),
   .det_n      (det_n)
);

// File: tb/auto_line_act_tb.sv
module auto_line_act_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 128;
   localparam logic [2:0] S_PD = 3'd0, S_HIZ = 3'd1, S_STBY = 3'd2,
                          S_ACT = 3'd3, S_RING = 3'd4, S_OHT = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_word = 3'b100;
   logic       ohf_hi = 1'b0, ohf_act = 1'b0, ring_trip = 1'b0, ring_clk = 1'b0;
   logic [2:0] feed_state;
   logic       rev_pol, det_n;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   auto_line_act u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_word  (mode_word),
      .ohf_hi     (ohf_hi),
      .ohf_act    (ohf_act),
      .ring_trip  (ring_trip),
      .ring_clk   (ring_clk),
      .feed_state (feed_state),
      .rev_pol    (rev_pol),
      .det_n      (det_n)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic ring_edges(input int n);
      for (int i = 0; i < n; i++) begin
         ring_clk = 1'b1; step(4);
         ring_clk = 1'b0; step(4);
      end
   endtask

   task automatic go_active();
      ohf_act = 1'b0; ohf_hi = 1'b1; step(2);
      ohf_hi = 1'b0; ohf_act = 1'b1; step(2);
   endtask

   function automatic logic [2:0] after_break(input int n, input logic [2:0] w);
      if (n >= HOLD && w[2] && w[1:0] != 2'b10) return S_HIZ;
      return S_ACT;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      step(3);
      chk("R1 state in reset", feed_state, S_PD);
      chk("R1 det in reset", det_n, 1);
      chk("R1 pol in reset", rev_pol, 0);
      rst_n = 1'b1; step(3);
      chk("R2 hiz after reset", feed_state, S_HIZ);

      ohf_hi = 1'b1; step(2);
      chk("R3 hiz to stby", feed_state, S_STBY);
      ohf_hi = 1'b0;
      ring_edges(HOLD - 1);
      chk("R5 stby at 127", feed_state, S_STBY);
      ring_edges(1);
      chk("R5 stby timeout", feed_state, S_HIZ);

      go_active();
      chk("R4 stby to active", feed_state, S_ACT);
      chk("R4 det low", det_n, 0);

      ohf_act = 1'b0; step(1);
      chk("R6 det high at once", det_n, 1);
      chk("R6 state held", feed_state, S_ACT);
      ring_edges(100);
      chk("R6 held at 100", feed_state, S_ACT);
      ohf_act = 1'b1; step(2);
      chk("R7 returns active", feed_state, S_ACT);
      chk("R7 det low", det_n, 0);
      ohf_act = 1'b0;
      ring_edges(HOLD - 1);
      chk("R7 fresh count", feed_state, S_ACT);
      ring_edges(1);
      chk("R8 default fallback", feed_state, S_HIZ);

      // random break lengths around the window (pulse dialling)
      go_active();
      for (int k = 0; k < 8; k++) begin
         int n;
         n = $urandom_range(170, 40);
         ohf_act = 1'b0;
         ring_edges(n);
         chk("R7 random break", feed_state, after_break(n, mode_word));
         if (feed_state == S_ACT) begin
            chk("R6 det during break", det_n, 1);
            ohf_act = 1'b1; step(2);
            chk("R7 det after break", det_n, 0);
         end else begin
            go_active();
         end
      end
      if (feed_state != S_ACT) go_active();

      mode_word = 3'b110; step(2);
      chk("R12 intra word keeps active", feed_state, S_ACT);
      chk("R12 polarity updated", rev_pol, 1);
      ohf_act = 1'b0;
      ring_edges(HOLD + 2);
      chk("R8 reverse held", feed_state, S_ACT);
      chk("R8 reverse pol", rev_pol, 1);

      mode_word = 3'b000; step(2);
      chk("R11 pwrdn", feed_state, S_PD);
      chk("R11 det high", det_n, 1);
      chk("R11 pol direct", rev_pol, 0);
      mode_word = 3'b110; step(2);
      chk("R2 hiz from 110", feed_state, S_HIZ);
      chk("R2 hiz direct", rev_pol, 0);

      ohf_hi = 1'b1; step(2); ohf_hi = 1'b0;
      chk("R3 stby again", feed_state, S_STBY);
      mode_word = 3'b011; step(2);
      chk("R11 oht entered", feed_state, S_OHT);
      ring_edges(HOLD + 60);
      chk("R11 timeout cancelled", feed_state, S_OHT);
      chk("R10 oht direct", rev_pol, 0);
      mode_word = 3'b010; step(2);
      chk("R10 oht reverse", rev_pol, 1);
      ohf_act = 1'b1; step(2);
      chk("R10 oht to active", feed_state, S_ACT);
      chk("R10 active reverse", rev_pol, 1);
      ohf_act = 1'b0;

      mode_word = 3'b001; step(2);
      chk("R9 ringing", feed_state, S_RING);
      chk("R9 det idle", det_n, 1);
      ring_trip = 1'b1; step(1); ring_trip = 1'b0; step(1);
      chk("R9 trip to active", feed_state, S_ACT);
      chk("R9 det latched", det_n, 0);
      ring_edges(HOLD + 12);
      chk("R9 latch holds", det_n, 0);
      chk("R9 no fallback", feed_state, S_ACT);
      mode_word = 3'b000; step(2);
      chk("R9 latch released", det_n, 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule